// File: doc/BRIEF.md
# Deep-Sleep Watchdog Timer

This block is a watchdog that is only live while the chip sits in its deepest low-power state. It counts ticks from one of two slow clock sources, a crystal oscillator or an on-chip RC oscillator, chosen by a configuration bit. The timeout length is set by a 4-bit code that picks a power-of-two terminal count. When the count reaches that terminal value, the block raises a single-cycle timeout event that the wake logic turns into a wake-up or reset. The watchdog has its own enable bit and does not depend on the normal run-mode watchdog.

Each deep-sleep entry strobe clears the count, so every deep-sleep stay starts a fresh period. The chosen oscillator may be stopped when the chip enters deep sleep. In that case the block asserts a request to start it and holds that request for the rest of the deep-sleep stay. Ticks are counted only once the oscillator reports that it is enabled, so the first timeout comes late by however long the oscillator took to start. After a timeout the counter holds its value and stays silent until the next entry.

All inputs are synchronous to `clk`. A tick input is a single-cycle qualifier that marks one edge of the slow clock.

Top module: `dswdt_top`

## Requirements
- R1: After reset, `timeout` and `osc_req` are both 0.
- R2: Code `c` on `cfg_ps` sets a terminal count of 2^(6+2c) counted ticks, so code 0 gives 64 and code 3 gives 4096. `timeout` goes to 1 in the cycle after the clock edge that counts the terminal tick, and it stays high for exactly one cycle.
- R3: After a timeout, further ticks produce no new timeout until the next `ds_enter`.
- R4: A `ds_enter` pulse clears the count, and no tick is counted in that cycle. Ticks counted before a re-entry do not shorten the next period. The cycle after `ds_enter` never shows `timeout`.
- R5: `cfg_src_sel` = 0 selects source A (`a_en`, `a_tick`), the crystal oscillator. `cfg_src_sel` = 1 selects source B (`b_en`, `b_tick`), the RC oscillator. Ticks on the source that is not selected have no effect on the count.
- R6: A tick is ignored while the selected source's enable is 0. Counting starts only once that enable is 1.
- R7: Ticks are ignored while `ds_active` is 0. The count reached so far is kept.
- R8: While `cfg_en` is 0, no tick is counted, and in the following cycle `osc_req` is 0.
- R9: When `ds_active` and `cfg_en` are both 1 and the selected enable is 0, `osc_req` is 1 in the next cycle. It then stays 1 while `ds_active` and `cfg_en` stay 1, even after the enable rises. It drops to 0 in the cycle after `ds_active` falls. If the selected enable is 1 throughout, `osc_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Watchdog enable configuration bit |
| cfg_src_sel | input | 1 | Source select: 0 crystal (A), 1 RC (B) |
| cfg_ps | input | 4 | Postscaler code, terminal count 2^(6+2*code) |
| a_en | input | 1 | Source A running |
| a_tick | input | 1 | Source A tick qualifier |
| b_en | input | 1 | Source B running |
| b_tick | input | 1 | Source B tick qualifier |
| ds_active | input | 1 | Deep-sleep state is active |
| ds_enter | input | 1 | Deep-sleep entry strobe |
| timeout | output | 1 | One-cycle timeout event |
| osc_req | output | 1 | Request to turn on the selected oscillator |

## Verification
The assertions check on every cycle that a timeout lasts only one cycle and always follows a qualified tick on the selected source. They also check that an entry cycle is never followed by a timeout, and that a disabled watchdog or an inactive deep-sleep state keeps the oscillator request low. They check the request's set and hold behaviour as well. The exact period for each code, the restart after re-entry, and the absence of any second timeout over a long run of ticks all depend on counting across many cycles, so only the bench scenarios can show them.

// File: rtl/dswdt_pkg.sv
package dswdt_pkg;

    typedef enum logic {
        SRC_CRYSTAL = 1'b0,
        SRC_RCOSC   = 1'b1
    } dswdt_src_e;

    function automatic int unsigned term_exp(input int unsigned code,
                                             input int unsigned min_exp,
                                             input int unsigned step);
        return min_exp + code * step;
    endfunction

endpackage

// File: rtl/dswdt_src_mux.sv
module dswdt_src_mux
    import dswdt_pkg::*;
(
    input  logic sel,
    input  logic a_en,
    input  logic a_tick,
    input  logic b_en,
    input  logic b_tick,
    output logic sel_en,
    output logic sel_tick
);
    always_comb begin
        if (dswdt_src_e'(sel) == SRC_RCOSC) begin
            sel_en   = b_en;
            sel_tick = b_tick;
        end else begin
            sel_en   = a_en;
            sel_tick = a_tick;
        end
    end
endmodule

// File: rtl/dswdt_limit.sv
module dswdt_limit
    import dswdt_pkg::*;
#(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MIN_EXP  = 6,
    parameter int unsigned EXP_STEP = 2,
    parameter int unsigned CNT_W    = MIN_EXP + ((1 << CODE_W) - 1) * EXP_STEP + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);
    localparam int unsigned NCODES = 1 << CODE_W;

    logic [CNT_W-1:0] table_w [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_lim
        localparam int unsigned EXPV = term_exp(g, MIN_EXP, EXP_STEP);
        assign table_w[g] = {{(CNT_W-1){1'b0}}, 1'b1} << EXPV;
    end

    assign limit = table_w[code];
endmodule

// File: rtl/dswdt_ctr.sv
module dswdt_ctr #(
    parameter int unsigned CNT_W = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             fire;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [CNT_W-1:0] nxt_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        nxt_cnt   = st_q.cnt + 1'b1;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (cnt_en && !st_q.done) begin
            st_d.cnt = nxt_cnt;
            if (nxt_cnt >= limit) begin
                st_d.done = 1'b1;
                st_d.fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = st_q.fire;
endmodule

// File: rtl/dswdt_req.sv
module dswdt_req (
    input  logic clk,
    input  logic rst_n,
    input  logic ds_active,
    input  logic cfg_en,
    input  logic sel_en,
    output logic osc_req
);
    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d.req = ds_active && cfg_en && (st_q.req || !sel_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign osc_req = st_q.req;
endmodule

// File: rtl/dswdt_top.sv
module dswdt_top #(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MIN_EXP  = 6,
    parameter int unsigned EXP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_src_sel,
    input  logic [CODE_W-1:0] cfg_ps,
    input  logic              a_en,
    input  logic              a_tick,
    input  logic              b_en,
    input  logic              b_tick,
    input  logic              ds_active,
    input  logic              ds_enter,
    output logic              timeout,
    output logic              osc_req
);
    localparam int unsigned CNT_W = MIN_EXP + ((1 << CODE_W) - 1) * EXP_STEP + 1;

    logic             sel_en;
    logic             sel_tick;
    logic [CNT_W-1:0] limit;
    logic             cnt_en;

    dswdt_src_mux u_mux (
        .sel      (cfg_src_sel),
        .a_en     (a_en),
        .a_tick   (a_tick),
        .b_en     (b_en),
        .b_tick   (b_tick),
        .sel_en   (sel_en),
        .sel_tick (sel_tick)
    );

    dswdt_limit #(
        .CODE_W   (CODE_W),
        .MIN_EXP  (MIN_EXP),
        .EXP_STEP (EXP_STEP),
        .CNT_W    (CNT_W)
    ) u_lim (
        .code  (cfg_ps),
        .limit (limit)
    );

    assign cnt_en = ds_active && cfg_en && sel_en && sel_tick;

    dswdt_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ds_enter),
        .cnt_en (cnt_en),
        .limit  (limit),
        .fire   (timeout)
    );

    dswdt_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .ds_active (ds_active),
        .cfg_en    (cfg_en),
        .sel_en    (sel_en),
        .osc_req   (osc_req)
    );
endmodule

// File: rtl/dswdt_chk.sv
module dswdt_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_src_sel,
    input logic a_en,
    input logic a_tick,
    input logic b_en,
    input logic b_tick,
    input logic ds_active,
    input logic ds_enter,
    input logic timeout,
    input logic osc_req
);
    logic en_c, tick_c;
    assign en_c   = cfg_src_sel ? b_en   : a_en;
    assign tick_c = cfg_src_sel ? b_tick : a_tick;

    // R2: the event lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R5/R6/R7: a timeout always follows a qualified tick on the selected source
    a_r5_tick_before_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(ds_active && cfg_en && en_c && tick_c && !ds_enter));

    // R4: the entry cycle cannot end a period
    a_r4_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ds_enter |=> !timeout);

    // R8: a disabled watchdog never requests a clock and never times out
    a_r8_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!osc_req && !timeout));

    // R9: request released when deep sleep ends
    a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_active |=> !osc_req);

    // R9: stopped clock triggers the request
    a_r9_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_active && cfg_en && !en_c) |=> osc_req);

    // R9: request held for the rest of the stay
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_req && ds_active && cfg_en) |=> osc_req);
endmodule

bind dswdt_top dswdt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_src_sel (cfg_src_sel),
    .a_en        (a_en),
    .a_tick      (a_tick),
    .b_en        (b_en),
    .b_tick      (b_tick),
    .ds_active   (ds_active),
    .ds_enter    (ds_enter),
    .timeout     (timeout),
    .osc_req     (osc_req)
);

// File: tb/dswdt_top_tb_top.sv
`timescale 1ns/1ps
module dswdt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_src_sel = 1'b0;
    logic [3:0] cfg_ps = 4'd0;
    logic       a_en = 1'b0, a_tick = 1'b0, b_en = 1'b0, b_tick = 1'b0;
    logic       ds_active = 1'b0, ds_enter = 1'b0;
    logic       timeout, osc_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dswdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_sel(cfg_src_sel),
        .cfg_ps(cfg_ps), .a_en(a_en), .a_tick(a_tick), .b_en(b_en), .b_tick(b_tick),
        .ds_active(ds_active), .ds_enter(ds_enter), .timeout(timeout), .osc_req(osc_req)
    );

    // {noise, sel, code}
    localparam logic [5:0] VEC_TAB [0:4] = '{
        6'b0_0_0000, 6'b0_1_0000, 6'b1_0_0001, 6'b1_1_0010, 6'b0_0_0011
    };

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_ticks(input logic sel, input logic t, input logic noise);
        if (sel) begin b_tick = t; a_tick = noise; end
        else     begin a_tick = t; b_tick = noise; end
    endtask

    task automatic enter_ds(input logic sel, input logic [3:0] code);
        @(negedge clk);
        cfg_src_sel = sel; cfg_ps = code; ds_active = 1'b1; ds_enter = 1'b1;
        drive_ticks(sel, 1'b1, 1'b1);
        @(negedge clk);
        ds_enter = 1'b0;
        drive_ticks(sel, 1'b0, 1'b0);
    endtask

    task automatic count_to_timeout(input logic sel, input logic noise,
                                    input int max_cyc, output int got);
        int k;
        logic t;
        k = 0; got = -1;
        for (int c = 0; c < max_cyc && got < 0; c++) begin
            t = noise ? c[0] : 1'b1;
            drive_ticks(sel, t, noise);
            @(negedge clk);
            if (t) k++;
            if (timeout) got = k;
        end
        drive_ticks(sel, 1'b0, 1'b0);
    endtask

    task automatic count_pulses(input logic sel, input int cyc, output int pulses);
        pulses = 0;
        for (int c = 0; c < cyc; c++) begin
            drive_ticks(sel, 1'b1, 1'b1);
            @(negedge clk);
            if (timeout) pulses++;
        end
        drive_ticks(sel, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int got, pulses, expv;
        // R1 reset state
        repeat (3) @(negedge clk);
        check_int("R1 timeout", int'(timeout), 0);
        check_int("R1 osc_req", int'(osc_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_en = 1'b1; a_en = 1'b1; b_en = 1'b1;

        // table walk: R2 period per code, R5 selection with noise, R3 hold
        for (int i = 0; i < 5; i++) begin
            logic noise, sel;
            logic [3:0] code;
            {noise, sel, code} = VEC_TAB[i];
            expv = 1 << (6 + 2 * int'(code));
            enter_ds(sel, code);
            count_to_timeout(sel, noise, 3 * expv, got);
            check_int(noise ? "R5 period with other source noise" : "R2 period", got, expv);
            @(negedge clk);
            check_int("R2 single-cycle pulse", int'(timeout), 0);
            count_pulses(sel, 80, pulses);
            check_int("R3 no repeat after timeout", pulses, 0);
            check_int("R9 no request while clock runs", int'(osc_req), 0);
        end

        // R4 re-entry restarts the period
        enter_ds(1'b0, 4'd0);
        for (int c = 0; c < 40; c++) begin
            drive_ticks(1'b0, 1'b1, 1'b0);
            @(negedge clk);
        end
        enter_ds(1'b0, 4'd0);
        count_to_timeout(1'b0, 1'b0, 200, got);
        check_int("R4 full period after re-entry", got, 64);

        // R6/R9 clock off at entry: request, late start
        a_en = 1'b0;
        enter_ds(1'b0, 4'd0);
        check_int("R9 request when clock off", int'(osc_req), 1);
        count_pulses(1'b0, 150, pulses);
        check_int("R6 ticks ignored while source off", pulses, 0);
        a_en = 1'b1;
        count_to_timeout(1'b0, 1'b0, 200, got);
        check_int("R6 count starts at enable", got, 64);
        check_int("R9 request held after enable", int'(osc_req), 1);
        ds_active = 1'b0;
        @(negedge clk);
        check_int("R9 request drops after exit", int'(osc_req), 0);

        // R7 ticks ignored outside deep sleep, count kept
        enter_ds(1'b1, 4'd0);
        for (int c = 0; c < 30; c++) begin
            drive_ticks(1'b1, 1'b1, 1'b0);
            @(negedge clk);
        end
        ds_active = 1'b0;
        count_pulses(1'b1, 150, pulses);
        check_int("R7 no timeout outside deep sleep", pulses, 0);
        ds_active = 1'b1;
        count_to_timeout(1'b1, 1'b0, 200, got);
        check_int("R7 count resumes from kept value", got, 34);

        // R8 disabled watchdog
        cfg_en = 1'b0; b_en = 1'b0;
        enter_ds(1'b1, 4'd0);
        count_pulses(1'b1, 150, pulses);
        check_int("R8 no timeout when disabled", pulses, 0);
        check_int("R8 no request when disabled", int'(osc_req), 0);
        ds_active = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule